// File: doc/BRIEF.md
# Scripted Two-Wire Bus Master

This block drives a two-wire (I2C) bus from a small script held in a six-byte command memory. The memory is divided into three slots. Each slot has a control byte and a data byte. The upper nibble of the control byte selects what happens before the byte: a START, a STOP, a plain byte, or nothing at all. The lower nibble selects what the master does in the acknowledge clock, and whether a STOP follows.

A one-cycle `go` pulse makes the block walk the slots in order: slot 0, then 1, then 2. It does not run a bit-rate divider of its own. Every bus step is paced by a rising edge on `host_sck`, the serial clock of the host that issued the command.

Both bus lines are open-drain. The block only requests that a line be pulled low, and it reads SDA back from the pad. The level sampled on each data clock replaces the slot's data byte. This lets a later host read return what a slave sent, or confirm what was written. The sampled acknowledge level is stored in the control byte.

Longer messages are built by issuing `go` again with new slot contents. The bus lines keep their levels between runs.

Top module: `ctlreg_i2c_master`

## Requirements
- R1: After reset, neither line is pulled, `busy` is low, and all six command bytes read 0.
- R2: Byte 2k holds slot k's control, with the pre-code in [7:4] and the post-code in [3:0]. Byte 2k+1 holds slot k's data. A host write to an idle block is returned by a read, with `cfg_rdata` valid one clock after `cfg_raddr`.
- R3: A `go` pulse sets `busy` and processes slots 0, 1, 2 in that order. `busy` clears after slot 2. While `busy` is high, `go` and host writes have no effect.
- R4: Pre-code 0110 issues SCL low, SDA released, SCL released, SDA low (a START), then sends the slot's byte.
- R5: Pre-code 0001 issues SCL low, SDA low, SCL released, SDA released (a STOP) and sends no byte.
- R6: Pre-code 0000 sends the slot's byte with no START or STOP in front.
- R7: Any other pre-code skips the slot, post-code included, and the lines are not touched.
- R8: A byte is eight data clocks sent MSB first, followed by one acknowledge clock. Each clock takes four host edges: SCL low, SDA set, SCL released, sample. SDA changes while SCL is released only in the last step of a START or STOP.
- R9: In the acknowledge clock the master pulls SDA low when post-code bit 3 is 0, and releases it when that bit is 1. Post-code 1001 is followed by a STOP.
- R10: The eight sampled data levels overwrite the slot's data byte. The sampled acknowledge level (0 = acknowledged) overwrites bit 3 of the control byte. A released byte therefore returns what the slave drove.
- R11: Line levels are kept between runs. After a byte with no STOP, SCL stays released and SDA stays at the acknowledge level.
- R12: Bus steps advance only on rising edges of `host_sck`. Without edges the lines hold even while `busy` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| host_sck | input | 1 | Host serial clock; each rising edge paces one bus step |
| go | input | 1 | One-cycle pulse that starts a run over the slots |
| cfg_we | input | 1 | Host write strobe for the command memory |
| cfg_addr | input | 3 | Host write byte address |
| cfg_wdata | input | 8 | Host write data |
| cfg_raddr | input | 3 | Host read byte address |
| cfg_rdata | output | 8 | Registered host read data |
| sda_in | input | 1 | SDA level seen at the pad |
| scl_pull | output | 1 | 1 pulls SCL low, 0 releases it |
| sda_pull | output | 1 | 1 pulls SDA low, 0 releases it |
| busy | output | 1 | High while a run is in progress |

## Verification
The hardest case to reach is a released byte that the slave actually drives, captured into memory in the middle of a run. This needs a slave that counts SCL pulses across runs and across slots with no START. The bench's bus model keeps its bit counter running across runs and only drives data for a chosen byte index. The run places that byte in a plain slot right after an addressed slot, and checks the captured value and the NACK bit it leaves behind. A second hard case is a run held with `host_sck` stopped. The bench gates the host clock, then writes and pulses `go` during the stall, and only then lets the run finish.

// File: rtl/cim_pkg.sv
package cim_pkg;
  localparam int BYTE_W = 8;
  localparam int NIB_W  = 4;

  localparam logic [NIB_W-1:0] PRE_START = 4'b0110;
  localparam logic [NIB_W-1:0] PRE_STOP  = 4'b0001;
  localparam logic [NIB_W-1:0] PRE_PLAIN = 4'b0000;
  localparam logic [NIB_W-1:0] POST_NACK_STOP = 4'b1001;

  typedef enum logic [2:0] {
    E_IDLE,
    E_LOAD,
    E_COND,
    E_BIT,
    E_NEXT
  } eng_st_e;
endpackage

// File: rtl/cim_regfile.sv
module cim_regfile #(
  parameter int NSLOT = 3,
  parameter int AW    = $clog2(2 * NSLOT),
  parameter int SW    = (NSLOT > 1) ? $clog2(NSLOT) : 1
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          h_we,
  input  logic [AW-1:0] h_addr,
  input  logic [7:0]    h_wdata,
  input  logic          e_we,
  input  logic [AW-1:0] e_addr,
  input  logic [7:0]    e_wdata,
  input  logic [AW-1:0] r_addr,
  output logic [7:0]    r_data,
  input  logic [SW-1:0] s_idx,
  output logic [7:0]    s_ctrl,
  output logic [7:0]    s_data
);
  localparam int NB = 2 * NSLOT;

  logic [7:0] mem [NB];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < NB; i++) mem[i] <= '0;
      r_data <= '0;
    end else begin
      if (e_we) begin
        if (int'(e_addr) < NB) mem[e_addr] <= e_wdata;
      end else if (h_we) begin
        if (int'(h_addr) < NB) mem[h_addr] <= h_wdata;
      end
      r_data <= (int'(r_addr) < NB) ? mem[r_addr] : '0;
    end
  end

  assign s_ctrl = mem[{s_idx, 1'b0}];
  assign s_data = mem[{s_idx, 1'b1}];

  // R10
  wb_excl_chk: assert property (@(posedge clk) disable iff (rst)
    e_we |-> (int'(e_addr) < NB));
endmodule

// File: rtl/cim_pace.sv
module cim_pace #(
  parameter int SYNC = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic host_sck,
  input  logic sda_pad,
  output logic tick,
  output logic sda_s
);
  logic [SYNC-1:0] sck_sr;
  logic [SYNC-1:0] sda_sr;
  logic            sck_d;

  always_ff @(posedge clk) begin
    if (rst) begin
      sck_sr <= '0;
      sda_sr <= '1;
      sck_d  <= 1'b0;
      tick   <= 1'b0;
    end else begin
      sck_sr <= {sck_sr[SYNC-2:0], host_sck};
      sda_sr <= {sda_sr[SYNC-2:0], sda_pad};
      sck_d  <= sck_sr[SYNC-1];
      tick   <= sck_sr[SYNC-1] & ~sck_d;
    end
  end

  assign sda_s = sda_sr[SYNC-1];

  // R12
  tick_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    tick |=> !tick);
endmodule

// File: rtl/cim_engine.sv
module cim_engine
  import cim_pkg::*;
#(
  parameter int NSLOT = 3,
  parameter int AW    = $clog2(2 * NSLOT),
  parameter int SW    = (NSLOT > 1) ? $clog2(NSLOT) : 1
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          go,
  input  logic          tick,
  input  logic          sda_s,
  input  logic [7:0]    ctrl_byte,
  input  logic [7:0]    data_byte,
  output logic [SW-1:0] slot,
  output logic          scl_pull,
  output logic          sda_pull,
  output logic          busy,
  output logic          eng_we,
  output logic [AW-1:0] eng_addr,
  output logic [7:0]    eng_wdata
);
  localparam logic [3:0] LAST_BIT = 4'(BYTE_W);
  localparam logic [SW-1:0] LAST_SLOT = SW'(NSLOT - 1);

  eng_st_e    st;
  logic [1:0] step;
  logic [3:0] bitn;
  logic [7:0] shreg;
  logic [6:0] rxsh;
  logic [3:0] pre_c;
  logic [3:0] post_c;
  logic       cond_stop;

  always_ff @(posedge clk) begin
    if (rst) begin
      st        <= E_IDLE;
      slot      <= '0;
      step      <= '0;
      bitn      <= '0;
      shreg     <= '0;
      rxsh      <= '0;
      pre_c     <= '0;
      post_c    <= '0;
      cond_stop <= 1'b0;
      scl_pull  <= 1'b0;
      sda_pull  <= 1'b0;
      busy      <= 1'b0;
      eng_we    <= 1'b0;
      eng_addr  <= '0;
      eng_wdata <= '0;
    end else begin
      eng_we <= 1'b0;
      case (st)
        E_IDLE: begin
          if (go) begin
            st   <= E_LOAD;
            slot <= '0;
            busy <= 1'b1;
          end
        end
        E_LOAD: begin
          pre_c  <= ctrl_byte[7:4];
          post_c <= ctrl_byte[3:0];
          shreg  <= data_byte;
          step   <= '0;
          bitn   <= '0;
          case (ctrl_byte[7:4])
            PRE_START: begin st <= E_COND; cond_stop <= 1'b0; end
            PRE_STOP:  begin st <= E_COND; cond_stop <= 1'b1; end
            PRE_PLAIN: st <= E_BIT;
            default:   st <= E_NEXT;
          endcase
        end
        E_COND: begin
          if (tick) begin
            step <= step + 2'd1;
            case (step)
              2'd0: scl_pull <= 1'b1;
              2'd1: sda_pull <= cond_stop;
              2'd2: scl_pull <= 1'b0;
              default: begin
                sda_pull <= ~cond_stop;
                st       <= cond_stop ? E_NEXT : E_BIT;
              end
            endcase
          end
        end
        E_BIT: begin
          if (tick) begin
            step <= step + 2'd1;
            case (step)
              2'd0: scl_pull <= 1'b1;
              2'd1: sda_pull <= (bitn == LAST_BIT) ? ~post_c[3] : ~shreg[7];
              2'd2: scl_pull <= 1'b0;
              default: begin
                rxsh <= {rxsh[5:0], sda_s};
                bitn <= bitn + 4'd1;
                if (bitn < LAST_BIT) shreg <= {shreg[6:0], 1'b1};
                if (bitn == LAST_BIT - 4'd1) begin
                  eng_we    <= 1'b1;
                  eng_addr  <= {slot, 1'b1};
                  eng_wdata <= {rxsh, sda_s};
                end
                if (bitn == LAST_BIT) begin
                  eng_we    <= 1'b1;
                  eng_addr  <= {slot, 1'b0};
                  eng_wdata <= {pre_c, sda_s, post_c[2:0]};
                  if (post_c == POST_NACK_STOP) begin
                    st        <= E_COND;
                    cond_stop <= 1'b1;
                  end else begin
                    st <= E_NEXT;
                  end
                end
              end
            endcase
          end
        end
        E_NEXT: begin
          if (slot == LAST_SLOT) begin
            st   <= E_IDLE;
            busy <= 1'b0;
          end else begin
            slot <= slot + SW'(1);
            st   <= E_LOAD;
          end
        end
        default: st <= E_IDLE;
      endcase
    end
  end

  // R8
  sda_hold_chk: assert property (@(posedge clk) disable iff (rst)
    ((sda_pull != $past(sda_pull)) && !$past(scl_pull))
      |-> $past(st == E_COND && step == 2'd3));

  // R12
  step_on_tick_chk: assert property (@(posedge clk) disable iff (rst)
    !$past(tick) |-> (scl_pull == $past(scl_pull) && sda_pull == $past(sda_pull)));

  // R3
  idle_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    (!busy && !$past(busy)) |-> ($stable(scl_pull) && $stable(sda_pull)));

  // R8
  bit_range_chk: assert property (@(posedge clk) disable iff (rst)
    (st == E_BIT) |-> (bitn <= LAST_BIT));

  // R10
  wb_on_tick_chk: assert property (@(posedge clk) disable iff (rst)
    eng_we |-> $past(tick));
endmodule

// File: rtl/ctlreg_i2c_master.sv
module ctlreg_i2c_master #(
  parameter int NSLOT = 3,
  parameter int SYNC  = 2,
  parameter int AW    = $clog2(2 * NSLOT)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          host_sck,
  input  logic          go,
  input  logic          cfg_we,
  input  logic [AW-1:0] cfg_addr,
  input  logic [7:0]    cfg_wdata,
  input  logic [AW-1:0] cfg_raddr,
  output logic [7:0]    cfg_rdata,
  input  logic          sda_in,
  output logic          scl_pull,
  output logic          sda_pull,
  output logic          busy
);
  localparam int SW = (NSLOT > 1) ? $clog2(NSLOT) : 1;

  logic          tick;
  logic          sda_s;
  logic [SW-1:0] slot;
  logic [7:0]    ctrl_byte;
  logic [7:0]    data_byte;
  logic          eng_we;
  logic [AW-1:0] eng_addr;
  logic [7:0]    eng_wdata;
  logic          host_we;

  assign host_we = cfg_we & ~busy;

  cim_pace #(.SYNC(SYNC)) u_pace (
    .clk      (clk),
    .rst      (rst),
    .host_sck (host_sck),
    .sda_pad  (sda_in),
    .tick     (tick),
    .sda_s    (sda_s)
  );

  cim_regfile #(.NSLOT(NSLOT), .AW(AW), .SW(SW)) u_mem (
    .clk     (clk),
    .rst     (rst),
    .h_we    (host_we),
    .h_addr  (cfg_addr),
    .h_wdata (cfg_wdata),
    .e_we    (eng_we),
    .e_addr  (eng_addr),
    .e_wdata (eng_wdata),
    .r_addr  (cfg_raddr),
    .r_data  (cfg_rdata),
    .s_idx   (slot),
    .s_ctrl  (ctrl_byte),
    .s_data  (data_byte)
  );

  cim_engine #(.NSLOT(NSLOT), .AW(AW), .SW(SW)) u_eng (
    .clk       (clk),
    .rst       (rst),
    .go        (go & ~busy),
    .tick      (tick),
    .sda_s     (sda_s),
    .ctrl_byte (ctrl_byte),
    .data_byte (data_byte),
    .slot      (slot),
    .scl_pull  (scl_pull),
    .sda_pull  (sda_pull),
    .busy      (busy),
    .eng_we    (eng_we),
    .eng_addr  (eng_addr),
    .eng_wdata (eng_wdata)
  );
endmodule

// File: tb/sim_ctlreg_i2c_master.sv
module sim_ctlreg_i2c_master;
  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic       rst = 1'b1;
  logic       host_sck = 1'b0;
  logic       go = 1'b0;
  logic       cfg_we = 1'b0;
  logic [2:0] cfg_addr = '0;
  logic [7:0] cfg_wdata = '0;
  logic [2:0] cfg_raddr = '0;
  logic [7:0] cfg_rdata;
  logic       scl_pull, sda_pull, busy;
  logic       slave_low = 1'b0;
  wire        scl_bus = ~scl_pull;
  wire        sda_bus = ~sda_pull & ~slave_low;

  ctlreg_i2c_master u0 (
    .clk(clk), .rst(rst), .host_sck(host_sck), .go(go),
    .cfg_we(cfg_we), .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata),
    .cfg_raddr(cfg_raddr), .cfg_rdata(cfg_rdata), .sda_in(sda_bus),
    .scl_pull(scl_pull), .sda_pull(sda_pull), .busy(busy)
  );

  int total = 0;
  int bad = 0;
  bit sck_en = 1'b1;

  // gated host serial clock, one rising edge every 6 system clocks
  initial begin
    forever begin
      repeat (3) @(negedge clk);
      if (sck_en) host_sck = ~host_sck;
    end
  end

  // bus monitor and slave model
  logic        p_scl = 1'b1, p_sda = 1'b1;
  int          cnt = 0;
  logic [7:0]  sh = '0;
  int          bytes_done = 0;
  logic [10:0] ev [16];
  int          ev_n = 0;
  bit          ack_en = 1'b0, rd_en = 1'b0;
  logic [7:0]  rd_byte = '0;
  int          rd_idx = -1;

  task automatic log_ev(input logic [10:0] e);
    if (ev_n < 16) ev[ev_n] = e;
    ev_n++;
  endtask

  always @(negedge clk) begin
    if (rst) begin
      p_scl = 1'b1; p_sda = 1'b1; cnt = 0; slave_low = 1'b0;
    end else begin
      if (scl_bus && p_scl && (sda_bus != p_sda)) begin
        log_ev({(sda_bus ? 2'd2 : 2'd1), 9'd0});
        cnt = 0;
      end else if (scl_bus && !p_scl) begin
        if (cnt < 8) begin
          sh = {sh[6:0], sda_bus};
          cnt++;
        end else begin
          log_ev({2'd3, sh, sda_bus});
          cnt = 0;
          bytes_done++;
        end
      end else if (!scl_bus && p_scl) begin
        if (cnt == 8) slave_low = ack_en && !(rd_en && bytes_done == rd_idx);
        else slave_low = rd_en && (bytes_done == rd_idx) && !rd_byte[7 - cnt];
      end
      p_scl = scl_bus;
      p_sda = sda_bus;
    end
  end

  task automatic summary();
    $display("  test done: total=%0d bad=%0d", total, bad);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    total++; bad++;
    $display("FAIL R3 watchdog: actual=unfinished expected=finished");
    summary();
    $finish;
  end

  task automatic check(input bit ok, input string req, input string what, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic wr(input int a, input logic [7:0] d);
    @(negedge clk);
    cfg_we = 1'b1; cfg_addr = 3'(a); cfg_wdata = d;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic rd(input int a, output logic [7:0] d);
    @(negedge clk);
    cfg_raddr = 3'(a);
    @(negedge clk);
    d = cfg_rdata;
  endtask

  // script and expected model
  logic [7:0]  sc [3];
  logic [7:0]  sd [3];
  logic [7:0]  exp_mem [6];
  logic [10:0] exp_ev [16];
  int          exp_n;
  bit          line_scl = 1'b1, line_sda = 1'b1;

  task automatic load_script();
    for (int i = 0; i < 3; i++) begin
      wr(2 * i, sc[i]);
      wr(2 * i + 1, sd[i]);
    end
  endtask

  task automatic build_exp();
    int bidx;
    exp_n = 0;
    bidx = bytes_done;
    for (int i = 0; i < 3; i++) begin
      logic [3:0] pre, post;
      bit send, rdb, ackl;
      logic [7:0] obs;
      pre = sc[i][7:4]; post = sc[i][3:0];
      exp_mem[2 * i] = sc[i];
      exp_mem[2 * i + 1] = sd[i];
      send = 1'b0;
      if (pre == 4'b0110) begin exp_ev[exp_n] = {2'd1, 9'd0}; exp_n++; send = 1'b1; end
      else if (pre == 4'b0001) begin exp_ev[exp_n] = {2'd2, 9'd0}; exp_n++; line_scl = 1; line_sda = 1; end
      else if (pre == 4'b0000) send = 1'b1;
      if (send) begin
        rdb  = rd_en && (bidx == rd_idx);
        obs  = sd[i] & (rdb ? rd_byte : 8'hFF);
        ackl = post[3] && !(ack_en && !rdb);
        exp_ev[exp_n] = {2'd3, obs, ackl}; exp_n++;
        exp_mem[2 * i + 1] = obs;
        exp_mem[2 * i] = {pre, ackl, post[2:0]};
        bidx++;
        line_scl = 1'b1; line_sda = ackl;
        if (post == 4'b1001) begin
          exp_ev[exp_n] = {2'd2, 9'd0}; exp_n++;
          line_scl = 1'b1; line_sda = 1'b1;
        end
      end
    end
  endtask

  task automatic pulse_go();
    @(negedge clk); go = 1'b1;
    @(negedge clk); go = 1'b0;
  endtask

  task automatic wait_done();
    int n;
    n = 0;
    while (busy && n < 4000) begin @(negedge clk); n++; end
    repeat (20) @(negedge clk);
  endtask

  task automatic verify(input string req);
    logic [7:0] v;
    // R8: every event, including unexpected START/STOP from SDA moving under a high SCL
    check(ev_n == exp_n, req, "event count", ev_n, exp_n);
    for (int k = 0; k < exp_n && k < 16; k++)
      check(ev[k] == exp_ev[k], req, "bus event", int'(ev[k]), int'(exp_ev[k]));
    check(busy == 1'b0, "R3", "busy after run", int'(busy), 0);
    for (int a = 0; a < 6; a++) begin
      rd(a, v);
      check(v == exp_mem[a], "R10", "readback", int'(v), int'(exp_mem[a]));
    end
    check(scl_bus == line_scl, "R11", "SCL level kept", int'(scl_bus), int'(line_scl));
    check(sda_bus == line_sda, "R11", "SDA level kept", int'(sda_bus), int'(line_sda));
  endtask

  initial begin
    logic [7:0] v;
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);

    // R1 reset state
    check(scl_pull == 1'b0 && sda_pull == 1'b0, "R1", "lines after reset", {scl_pull, sda_pull}, 0);
    check(busy == 1'b0, "R1", "busy after reset", int'(busy), 0);
    for (int a = 0; a < 6; a++) begin
      rd(a, v);
      check(v == 8'h00, "R1", "memory after reset", int'(v), 0);
    end

    // R2 host write and read back
    for (int a = 0; a < 6; a++) wr(a, 8'(8'h11 * (a + 3)));
    for (int a = 0; a < 6; a++) begin
      rd(a, v);
      check(v == 8'(8'h11 * (a + 3)), "R2", "host readback", int'(v), int'(8'(8'h11 * (a + 3))));
    end

    // R12 stalled host clock, R3 go and writes ignored while busy, R4 START + byte
    sc[0] = 8'h68; sd[0] = 8'hA5;
    sc[1] = 8'h09; sd[1] = 8'h3C;
    sc[2] = 8'hF0; sd[2] = 8'h77;
    ack_en = 1'b1; rd_en = 1'b0;
    load_script();
    build_exp();
    sck_en = 1'b0;
    repeat (8) @(negedge clk);
    ev_n = 0;
    pulse_go();
    repeat (300) @(negedge clk);
    check(busy == 1'b1, "R12", "busy while stalled", int'(busy), 1);
    check(scl_bus == 1'b1 && sda_bus == 1'b1, "R12", "lines hold while stalled", {scl_bus, sda_bus}, 3);
    check(ev_n == 0, "R12", "no events while stalled", ev_n, 0);
    wr(5, 8'h00);
    wr(4, 8'h60);
    pulse_go();
    sck_en = 1'b1;
    wait_done();
    verify("R4");

    // R10 slave-driven byte after an addressed byte; R9 NACK then STOP
    sc[0] = 8'h68; sd[0] = 8'hA1;
    sc[1] = 8'h09; sd[1] = 8'hFF;
    sc[2] = 8'hF0; sd[2] = 8'h00;
    ack_en = 1'b1; rd_en = 1'b1; rd_byte = 8'h96;
    rd_idx = bytes_done + 1;
    load_script();
    build_exp();
    ev_n = 0;
    pulse_go();
    wait_done();
    verify("R10");
    rd_en = 1'b0;

    // sweep: every pre-code in slot 0 (R4 R5 R6 R7), post-codes (R9), slave ack on and off
    for (int pre = 0; pre < 16; pre++) begin
      for (int fs = 0; fs < 3; fs++) begin
        for (int a = 0; a < 2; a++) begin
          logic [3:0] post2;
          string req;
          post2 = (fs == 0) ? 4'b0000 : ((fs == 1) ? 4'b1000 : 4'b1001);
          sc[0] = {4'(pre), 4'b1000}; sd[0] = 8'(8'h3C ^ (pre * 13 + fs));
          sc[1] = 8'h68;              sd[1] = 8'(8'h5A + pre);
          sc[2] = {4'b0000, post2};   sd[2] = 8'(8'hC3 ^ (pre * 7 + a));
          ack_en = bit'(a);
          if (pre == 6) req = "R4";
          else if (pre == 1) req = "R5";
          else if (pre == 0) req = "R6";
          else req = "R7";
          if (fs != 1 && pre == 3) req = "R9";
          load_script();
          build_exp();
          ev_n = 0;
          pulse_go();
          wait_done();
          verify(req);
        end
      end
    end

    summary();
    $finish;
  end
endmodule